// File: doc/BRIEF.md
# 1-Wire Time Slot Engine

This block produces the line waveform for one 1-Wire transaction step on an open-drain bus: either the long reset pulse with presence detection, or a single bit slot. All timing is counted in ticks of a one-cycle `tick` enable, which is nominally 1 µs and comes from a divider outside the block. The block never drives the line high. It only asserts `line_pull`, which the pad turns into a pull to ground. The external resistor restores the high level.

One slot type serves both directions. A slot with `slot_wval` = 0 writes a zero. A slot with `slot_wval` = 1 writes a one, and because the line is sampled during that slot, it also reads whatever a slave returns. During the reset sequence the presence sample is not taken at a fixed offset. The engine looks for the slave's falling edge within a bounded window and samples a fixed delay after that edge. If no edge appears, the result is "no device". The line input passes through a two-flop synchronizer before any edge detection or sampling.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset, `line_pull` = 0, `done` = 0, `bit_out` = 1 and `presence_n` = 1.
- R2: On a reset sequence, `line_pull` is high for exactly T_RSTL ticks. The line is then released for T_RSTH ticks, followed by the recovery gap, so the sequence spans T_RSTL+T_RSTH+T_REC ticks up to `done`.
- R3: If a synchronized falling edge of the line appears within PD_WIN ticks of the release, the line is sampled PD_DLY ticks after that edge. `presence_n` takes the sampled level, where 0 means a device answered. `presence_n` keeps that value until the next reset sequence.
- R4: If no falling edge appears within the PD_WIN window after release, `presence_n` becomes 1 (no device).
- R5: A bit slot holds `line_pull` high for T_LOW0 ticks when `slot_wval` = 0, and for T_LOW1 ticks when `slot_wval` = 1.
- R6: `bit_out` takes the synchronized line level at the T_RDV-th tick of the slot. A slot lasts T_SLOT ticks, and `bit_out` changes only during a slot.
- R7: After each slot or reset sequence, the line stays released for T_REC ticks. `done` is then high for exactly one clock, with `line_pull` low.
- R8: A request is accepted only while the engine is idle. Requests made while it is busy have no effect. When `rst_req` and `slot_req` arrive together, the reset sequence is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable, nominally 1 µs |
| rst_req | input | 1 | Start a reset/presence sequence (sampled when idle) |
| slot_req | input | 1 | Start a bit slot (sampled when idle) |
| slot_wval | input | 1 | Value written in the slot; 1 also performs a read |
| line_in | input | 1 | Raw level of the bus line |
| line_pull | output | 1 | Pull the line low when high |
| done | output | 1 | One-cycle end-of-operation strobe |
| bit_out | output | 1 | Line level sampled in the last slot |
| presence_n | output | 1 | Presence result, 0 = device answered |

## Verification
Some properties are checked by the assertions on every cycle:
- `done` is a single-cycle strobe and the line is released while it is high.
- The reset-low counter stays in range.
- A reset request from idle always wins over a slot request.
- `bit_out` and `presence_n` change only in the phase that owns them.
- The edge detector emits single pulses.

Other behaviour can only be shown by the bench scenarios, because it depends on what a slave does on the line. These are the exact low and total durations in ticks, and the presence decisions for an early long pulse, a pulse that ends before the sample point, an edge outside the window and a silent bus. They also cover read values against slaves holding the line for different times, and requests ignored while busy.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RLOW,
    ST_RHIGH,
    ST_SLOW,
    ST_SREL,
    ST_REC,
    ST_DONE
  } owm_state_e;

  typedef enum logic [1:0] {
    PD_OFF,
    PD_SEEK,
    PD_WAIT,
    PD_HELD
  } pd_phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0..lim
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // low time of a bit slot for the value being written
  function automatic int unsigned slot_low_len(input logic wval, input int unsigned t0,
                                               input int unsigned t1);
    return wval ? t1 : t0;
  endfunction

endpackage

// File: rtl/owm_line_sync.sv
module owm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_s    = sync_q;
  assign line_fall = prev_q & ~sync_q;

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> !line_fall);

endmodule

// File: rtl/owm_presence.sv
module owm_presence import owm_pkg::*; #(
  parameter int unsigned PD_WIN = 60,
  parameter int unsigned PD_DLY = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic active,
  input  logic line_s,
  input  logic line_fall,
  output logic presence_n
);
  localparam int unsigned PW = cnt_bits(max2(PD_WIN, PD_DLY));

  pd_phase_e     phase;
  logic [PW-1:0] t_cnt;
  logic          win_out, dly_out;

  assign win_out = active && phase == PD_SEEK && !line_fall && tick && t_cnt == PW'(PD_WIN - 1);
  assign dly_out = active && phase == PD_WAIT && tick && t_cnt == PW'(PD_DLY - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PD_OFF;
      t_cnt      <= '0;
      presence_n <= 1'b1;
    end else if (arm) begin
      phase <= PD_SEEK;
      t_cnt <= '0;
    end else if (!active) begin
      phase <= PD_OFF;
    end else begin
      unique case (phase)
        PD_SEEK: begin
          if (line_fall) begin
            phase <= PD_WAIT;
            t_cnt <= '0;
          end else if (win_out) begin
            presence_n <= 1'b1;
            phase      <= PD_HELD;
          end else if (tick) begin
            t_cnt <= t_cnt + 1'b1;
          end
        end
        PD_WAIT: begin
          if (dly_out) begin
            presence_n <= line_s;
            phase      <= PD_HELD;
          end else if (tick) begin
            t_cnt <= t_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  presence_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence_n) |-> $past(active));

  // R4
  seek_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PD_SEEK |-> t_cnt < PW'(PD_WIN));

endmodule

// File: rtl/owm_slot_fsm.sv
module owm_slot_fsm import owm_pkg::*; #(
  parameter int unsigned T_RSTL = 500,
  parameter int unsigned T_RSTH = 500,
  parameter int unsigned T_LOW0 = 60,
  parameter int unsigned T_LOW1 = 6,
  parameter int unsigned T_RDV  = 15,
  parameter int unsigned T_SLOT = 70,
  parameter int unsigned T_REC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rst_req,
  input  logic slot_req,
  input  logic slot_wval,
  input  logic line_s,
  output logic rlow_end,
  output logic in_rhigh,
  output logic bit_out,
  output logic line_pull,
  output logic done
);
  localparam int unsigned CW = cnt_bits(max2(max2(T_RSTL, T_RSTH), max2(T_SLOT, T_REC)));

  owm_state_e    state;
  logic [CW-1:0] cnt;
  logic          wval_q;
  logic [CW-1:0] low_lim;
  logic          rhigh_end, slow_end, srel_end, rec_end, sample_pt;

  assign low_lim   = CW'(slot_low_len(wval_q, T_LOW0, T_LOW1));
  assign rlow_end  = state == ST_RLOW  && tick && cnt == CW'(T_RSTL - 1);
  assign rhigh_end = state == ST_RHIGH && tick && cnt == CW'(T_RSTH - 1);
  assign slow_end  = state == ST_SLOW  && tick && cnt == low_lim - 1'b1;
  assign srel_end  = state == ST_SREL  && tick && cnt == CW'(T_SLOT - 1);
  assign rec_end   = state == ST_REC   && tick && cnt == CW'(T_REC - 1);
  assign sample_pt = (state == ST_SLOW || state == ST_SREL) && tick && cnt == CW'(T_RDV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wval_q  <= 1'b1;
      bit_out <= 1'b1;
    end else begin
      if (sample_pt) bit_out <= line_s;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (rst_req) begin
            state <= ST_RLOW;
          end else if (slot_req) begin
            state  <= ST_SLOW;
            wval_q <= slot_wval;
          end
        end
        ST_RLOW: begin
          if (rlow_end) begin
            state <= ST_RHIGH;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_RHIGH: begin
          if (rhigh_end) begin
            state <= ST_REC;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_SLOW: begin
          if (slow_end) state <= ST_SREL;
          if (tick) cnt <= cnt + 1'b1;
        end
        ST_SREL: begin
          if (srel_end) begin
            state <= ST_REC;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        ST_REC: begin
          if (rec_end) state <= ST_DONE;
          else if (tick) cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_rhigh  = state == ST_RHIGH;
  assign line_pull = state == ST_RLOW || state == ST_SLOW;
  assign done      = state == ST_DONE;

  // R2
  rlow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RLOW |-> cnt < CW'(T_RSTL));

  // R6
  bit_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_out) |-> ($past(state) == ST_SLOW || $past(state) == ST_SREL));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !line_pull);

  // R8
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rst_req) |=> state == ST_RLOW);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SLOW |=> (state == ST_SLOW || state == ST_SREL));

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine import owm_pkg::*; #(
  parameter int unsigned T_RSTL = 500,
  parameter int unsigned T_RSTH = 500,
  parameter int unsigned PD_WIN = 60,
  parameter int unsigned PD_DLY = 30,
  parameter int unsigned T_LOW0 = 60,
  parameter int unsigned T_LOW1 = 6,
  parameter int unsigned T_RDV  = 15,
  parameter int unsigned T_SLOT = 70,
  parameter int unsigned T_REC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rst_req,
  input  logic slot_req,
  input  logic slot_wval,
  input  logic line_in,
  output logic line_pull,
  output logic done,
  output logic bit_out,
  output logic presence_n
);
  logic line_s, line_fall, rlow_end, in_rhigh;

  owm_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_s    (line_s),
    .line_fall (line_fall)
  );

  owm_slot_fsm #(
    .T_RSTL(T_RSTL), .T_RSTH(T_RSTH), .T_LOW0(T_LOW0), .T_LOW1(T_LOW1),
    .T_RDV(T_RDV), .T_SLOT(T_SLOT), .T_REC(T_REC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rst_req   (rst_req),
    .slot_req  (slot_req),
    .slot_wval (slot_wval),
    .line_s    (line_s),
    .rlow_end  (rlow_end),
    .in_rhigh  (in_rhigh),
    .bit_out   (bit_out),
    .line_pull (line_pull),
    .done      (done)
  );

  owm_presence #(.PD_WIN(PD_WIN), .PD_DLY(PD_DLY)) u_pd (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .arm        (rlow_end),
    .active     (in_rhigh),
    .line_s     (line_s),
    .line_fall  (line_fall),
    .presence_n (presence_n)
  );

  // R3
  arm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rlow_end |=> (in_rhigh && !line_pull));

endmodule

// File: tb/tb_owm_slot_engine.sv
module tb_owm_slot_engine;
  localparam int T_RSTL = 500, T_RSTH = 500, PD_WIN = 60, PD_DLY = 30;
  localparam int T_LOW0 = 60, T_LOW1 = 6, T_RDV = 15, T_SLOT = 70, T_REC = 2;
  localparam int TICK_DIV = 4;
  localparam int NV = 10;

  // fields: [31] reset op, [30] write value, [29:20] slave delay, [19:10] slave hold, [0] expected
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 10'd15, 10'd120, 9'd0, 1'b0},  // R3 long answer
    {1'b1, 1'b0, 10'd50, 10'd120, 9'd0, 1'b0},  // R3 late edge still in window
    {1'b1, 1'b0, 10'd15, 10'd10,  9'd0, 1'b1},  // R3 short pulse gone at sample
    {1'b1, 1'b0, 10'd5,  10'd28,  9'd0, 1'b1},  // R3 short pulse, early edge
    {1'b1, 1'b0, 10'd70, 10'd100, 9'd0, 1'b1},  // R4 edge outside window
    {1'b1, 1'b0, 10'd0,  10'd0,   9'd0, 1'b1},  // R4 silent bus
    {1'b0, 1'b1, 10'd0,  10'd0,   9'd0, 1'b1},  // R6 read 1
    {1'b0, 1'b1, 10'd0,  10'd25,  9'd0, 1'b0},  // R6 slave holds past sample
    {1'b0, 1'b1, 10'd0,  10'd10,  9'd0, 1'b1},  // R6 slave releases early
    {1'b0, 1'b0, 10'd0,  10'd0,   9'd0, 1'b0}   // R5 write 0
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic rst_req = 1'b0, slot_req = 1'b0, slot_wval = 1'b0, slave_low = 1'b0;
  logic line_in, line_pull, done, bit_out, presence_n;
  int checks = 0, errors = 0;
  int m_low, m_total, m_done, m_pull_done;

  assign line_in = ~(line_pull | slave_low);

  owm_slot_engine #(
    .T_RSTL(T_RSTL), .T_RSTH(T_RSTH), .PD_WIN(PD_WIN), .PD_DLY(PD_DLY),
    .T_LOW0(T_LOW0), .T_LOW1(T_LOW1), .T_RDV(T_RDV), .T_SLOT(T_SLOT), .T_REC(T_REC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rst_req(rst_req), .slot_req(slot_req),
    .slot_wval(slot_wval), .line_in(line_in), .line_pull(line_pull), .done(done),
    .bit_out(bit_out), .presence_n(presence_n)
  );

  always #2 clk = ~clk;

  initial begin
    int d = 0;
    forever begin
      @(posedge clk);
      #1;
      d = (d + 1) % TICK_DIV;
      tick = (d == 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic run_op(input bit do_rst, input bit do_slot, input bit wval,
                        input int dly, input int len, input bit disturb);
    @(negedge clk);
    rst_req = do_rst; slot_req = do_slot; slot_wval = wval;
    m_low = 0; m_total = 0; m_done = 0; m_pull_done = 0;
    fork
      begin
        bit fin = 0;
        int k = 0;
        int after = 0;
        while (!fin) begin
          @(negedge clk);
          if (k == 0) begin rst_req = 0; slot_req = 0; end
          k++;
          if (disturb && k == 40) begin rst_req = 1; slot_req = 1; slot_wval = 0; end
          if (disturb && k == 41) begin rst_req = 0; slot_req = 0; end
          if (done) begin
            m_done++;
            if (line_pull) m_pull_done++;
          end else if (m_done == 0) begin
            if (tick) m_total++;
            if (tick && line_pull) m_low++;
          end
          if (m_done > 0) after++;
          if (after == 4) fin = 1;
        end
      end
      begin
        if (len > 0) begin
          while (!line_pull) @(negedge clk);
          if (do_rst) begin
            while (line_pull) @(negedge clk);
            wait_ticks(dly);
          end
          slave_low = 1'b1;
          wait_ticks(len);
          slave_low = 1'b0;
        end
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(line_pull == 0, "R1 line_pull", int'(line_pull), 0);
    check(done == 0, "R1 done", int'(done), 0);
    check(bit_out == 1, "R1 bit_out", int'(bit_out), 1);
    check(presence_n == 1, "R1 presence_n", int'(presence_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      int exp_low, exp_total, res;
      v = VEC[i];
      exp_low   = v[31] ? T_RSTL : (v[30] ? T_LOW1 : T_LOW0);
      exp_total = v[31] ? (T_RSTL + T_RSTH + T_REC) : (T_SLOT + T_REC);
      run_op(v[31], !v[31], v[30], int'(v[29:20]), int'(v[19:10]), 1'b0);
      res = v[31] ? int'(presence_n) : int'(bit_out);
      check(m_low == exp_low, v[31] ? "R2 reset low ticks" : "R5 slot low ticks", m_low, exp_low);
      check(m_total == exp_total, v[31] ? "R2 sequence ticks" : "R6 slot ticks", m_total, exp_total);
      check(res == int'(v[0]), v[31] ? "R3/R4 presence" : "R6 sampled bit", res, int'(v[0]));
      check(m_done == 1, "R7 done width", m_done, 1);
      check(m_pull_done == 0, "R7 line released at done", m_pull_done, 0);
    end

    // R3: presence result holds across a slot
    run_op(1, 0, 0, 15, 120, 0);
    check(presence_n == 0, "R3 presence after device", int'(presence_n), 0);
    run_op(0, 1, 1, 0, 0, 0);
    check(presence_n == 0, "R3 presence held over slot", int'(presence_n), 0);

    // R8: requests during a busy slot ignored
    run_op(0, 1, 1, 0, 0, 1);
    check(m_low == T_LOW1, "R8 busy low ticks", m_low, T_LOW1);
    check(m_total == T_SLOT + T_REC, "R8 busy total ticks", m_total, T_SLOT + T_REC);
    check(m_done == 1, "R8 single done", m_done, 1);
    repeat (20) @(negedge clk);
    check(line_pull == 0, "R8 no late start", int'(line_pull), 0);
    check(presence_n == 0, "R8 presence untouched", int'(presence_n), 0);

    // R8: reset wins over slot
    run_op(1, 1, 0, 0, 0, 0);
    check(m_low == T_RSTL, "R8 priority low ticks", m_low, T_RSTL);
    check(presence_n == 1, "R8 priority presence", int'(presence_n), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule